// File: doc/BRIEF.md
# DMA Channel Enable Bank

This block keeps two per-channel enable bitmaps for a 16-channel DMA engine. One bitmap gates hardware transfer requests, one for each channel. The other bitmap gates the error interrupt of each channel. Software reaches both bitmaps through a plain register port. A bitmap can be replaced as a whole word. A single channel's bit can also be set or cleared through write-only ports that take the channel number as data, so software never needs a read-modify-write sequence. A select-all bit in that data applies the set or clear to every channel at once.

On the hardware side, the block ANDs each channel's error indicator with that channel's error-interrupt enable and registers the result as the interrupt request line for the channel. When a channel completes its major loop and its descriptor flags that requests should stop, the block clears that channel's request-enable bit by itself. A hardware clear wins over any software write to the same bit in the same cycle.

The register port is a simple single-cycle interface. A write takes effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr` while `reg_rd` is high, and is zero otherwise. The port has no valid/ready handshake because the block never stalls an access.

Top module: `dma_chan_enable_bank`

## Requirements
- R1: After reset, `req_en`, `err_irq` and both bitmaps read back as zero.
- R2: A write to address 0 replaces all 16 request-enable bits, and a write to address 1 replaces all 16 error-interrupt-enable bits. Bit n belongs to channel n. Each bitmap reads back at its own address, and reading changes nothing.
- R3: `err_irq[n]` is 1 exactly one clock after a cycle in which `chan_err[n]` and error-interrupt-enable bit n are both 1. It is 0 one clock after any cycle in which either of them is 0.
- R4: A write to address 2 (request set) or address 4 (error-enable set) with data bit 6 equal to 0 sets the bit of the channel given by data bits 3:0 and leaves every other bit unchanged.
- R5: A write to address 3 (request clear) or address 5 (error-enable clear) with data bit 6 equal to 0 clears the bit of the channel given by data bits 3:0 and leaves every other bit unchanged.
- R6: When data bit 6 of a set or clear write is 1, the operation applies to all 16 channels, whatever bits 3:0 hold.
- R7: Data bits 4, 5 and 7 to 15 of a set or clear write have no effect.
- R8: Addresses 2 to 5 read back as zero. Addresses 6 and 7 read back as zero, and writes to them change nothing.
- R9: A cycle in which `major_done[n]` and `done_dis_req[n]` are both 1 clears request-enable bit n at that clock edge. When `done_dis_req[n]` is 0, completion leaves the bit unchanged.
- R10: If a hardware clear from R9 and a software write that would set the same request-enable bit happen in the same cycle, the bit ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, zero when not reading |
| chan_err | input | 16 | Per-channel error indicators |
| major_done | input | 16 | Per-channel major-loop completion pulses |
| done_dis_req | input | 16 | Per-channel descriptor flag: disable request on completion |
| req_en | output | 16 | Request-enable bitmap |
| err_irq | output | 16 | Registered per-channel error interrupt requests |

## Verification
A table of register writes takes both bitmaps from a scattered pattern to all-clear and all-set. Each entry mixes whole-word writes, single-channel set and clear, and select-all writes, and the bench reads both bitmaps back after every step. This tells a wrong channel index or a bit that leaks into a neighbour apart from a whole-word write that went wrong. Data words with the ignored bits set, with a select-all bit next to a nonzero channel field, and aimed at unmapped addresses separate a correct field decode from one that uses too many bits. Error patterns that overlap the enable bitmap only in part, sampled before and after a clock edge, show both the AND and the one-cycle latency. Completion pulses with and without the descriptor flag, and completions that collide with set and whole-word writes, show which side wins.

// File: rtl/dce_pkg.sv
package dce_pkg;
  // Register address map of the enable bank
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_REQ_WORD = 3'd0,
    A_ERR_WORD = 3'd1,
    A_REQ_SET  = 3'd2,
    A_REQ_CLR  = 3'd3,
    A_ERR_SET  = 3'd4,
    A_ERR_CLR  = 3'd5
  } dce_addr_e;
endpackage

// File: rtl/dce_chan_mask.sv
// Turns a set/clear write (channel field plus select-all bit) into a
// per-channel mask.
module dce_chan_mask #(
  parameter int unsigned NCH  = 16,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            all_sel,
  input  logic [CH_W-1:0] chan,
  output logic [NCH-1:0]  mask
);
  for (genvar i = 0; i < NCH; i++) begin : g_bit
    assign mask[i] = en & (all_sel | (chan == CH_W'(i)));
  end

  // R4/R5: without select-all, at most one channel is touched
  a_r4_single_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !all_sel) |-> $onehot0(mask));
  // R6: select-all touches every channel
  a_r6_all_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (en && all_sel) |-> (mask == {NCH{1'b1}}));
endmodule

// File: rtl/dce_bitmap.sv
// One enable bitmap: whole-word write, per-bit set/clear, hardware clear.
module dce_bitmap #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_word,
  input  logic [NCH-1:0] word,
  input  logic [NCH-1:0] set_mask,
  input  logic [NCH-1:0] clr_mask,
  input  logic [NCH-1:0] hw_clr,
  output logic [NCH-1:0] q
);
  logic [NCH-1:0] merged;
  logic [NCH-1:0] nxt;

  always_comb begin
    merged = wr_word ? word : (q | set_mask);
    nxt    = merged & ~clr_mask & ~hw_clr;   // R10: hardware clear last
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R2: whole-word write lands, except bits cleared by hardware
  a_r2_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_word |=> (q == ($past(word) & ~$past(hw_clr))));
  // R4: a set bit is 1 afterwards unless hardware cleared it
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask && !wr_word) |=>
      ((q & $past(set_mask) & ~$past(hw_clr)) == ($past(set_mask) & ~$past(hw_clr))));
  // R5: a cleared bit is 0 afterwards
  a_r5_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((q & $past(clr_mask)) == '0));
  // R9/R10: hardware clear always wins
  a_r9_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_clr) |=> ((q & $past(hw_clr)) == '0));
  // R7/R8: with no operation pending, the bitmap holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_word && set_mask == '0 && clr_mask == '0 && hw_clr == '0) |=> $stable(q));
endmodule

// File: rtl/dce_irq_gen.sv
// Registered per-channel error interrupt requests.
module dce_irq_gen #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] err,
  input  logic [NCH-1:0] en,
  output logic [NCH-1:0] irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= '0;
    else        irq <= err & en;
  end

  // R3: one-cycle latency from error-and-enable to request
  a_r3_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(err) & $past(en))));
endmodule

// File: rtl/dma_chan_enable_bank.sv
module dma_chan_enable_bank
  import dce_pkg::*;
#(
  parameter int unsigned NCH     = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned ALL_BIT = 6,
  localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NCH-1:0]    chan_err,
  input  logic [NCH-1:0]    major_done,
  input  logic [NCH-1:0]    done_dis_req,
  output logic [NCH-1:0]    req_en,
  output logic [NCH-1:0]    err_irq
);
  // Per-bitmap decode: index 0 = request enable, 1 = error-interrupt enable
  localparam int unsigned NMAP = 2;

  logic [NMAP-1:0] wr_word;
  logic [NMAP-1:0] set_en;
  logic [NMAP-1:0] clr_en;
  logic [NCH-1:0]  set_mask [NMAP];
  logic [NCH-1:0]  clr_mask [NMAP];
  logic [NCH-1:0]  hw_clr   [NMAP];
  logic [NCH-1:0]  q        [NMAP];
  logic [NCH-1:0]  err_en;

  always_comb begin
    wr_word[0] = reg_wr && (reg_addr == A_REQ_WORD);
    wr_word[1] = reg_wr && (reg_addr == A_ERR_WORD);
    set_en[0]  = reg_wr && (reg_addr == A_REQ_SET);
    set_en[1]  = reg_wr && (reg_addr == A_ERR_SET);
    clr_en[0]  = reg_wr && (reg_addr == A_REQ_CLR);
    clr_en[1]  = reg_wr && (reg_addr == A_ERR_CLR);
    hw_clr[0]  = major_done & done_dis_req;
    hw_clr[1]  = '0;
  end

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    dce_chan_mask #(.NCH(NCH)) u_set (
      .clk(clk), .rst_n(rst_n), .en(set_en[m]),
      .all_sel(reg_wdata[ALL_BIT]), .chan(reg_wdata[CH_W-1:0]),
      .mask(set_mask[m])
    );
    dce_chan_mask #(.NCH(NCH)) u_clr (
      .clk(clk), .rst_n(rst_n), .en(clr_en[m]),
      .all_sel(reg_wdata[ALL_BIT]), .chan(reg_wdata[CH_W-1:0]),
      .mask(clr_mask[m])
    );
    dce_bitmap #(.NCH(NCH)) u_map (
      .clk(clk), .rst_n(rst_n), .wr_word(wr_word[m]),
      .word(reg_wdata[NCH-1:0]), .set_mask(set_mask[m]),
      .clr_mask(clr_mask[m]), .hw_clr(hw_clr[m]), .q(q[m])
    );
  end

  assign req_en = q[0];
  assign err_en = q[1];

  dce_irq_gen #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .err(chan_err), .en(err_en), .irq(err_irq)
  );

  // Read mux: bitmaps at their own addresses, everything else zero (R8)
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == A_REQ_WORD)      reg_rdata = DW'(q[0]);
      else if (reg_addr == A_ERR_WORD) reg_rdata = DW'(q[1]);
    end
  end

  // R1: outputs are clear while reset is applied
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (req_en == '0 && err_irq == '0);
    end
  end
endmodule

// File: tb/dma_chan_enable_bank_test.sv
module dma_chan_enable_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] chan_err = '0;
  logic [15:0] major_done = '0;
  logic [15:0] done_dis_req = '0;
  logic [15:0] req_en;
  logic [15:0] err_irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_chan_enable_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chan_err(chan_err), .major_done(major_done), .done_dis_req(done_dis_req),
    .req_en(req_en), .err_irq(err_irq)
  );

  typedef struct packed {
    logic [2:0]  a;
    logic [15:0] d;
    logic [15:0] exp_req;
    logic [15:0] exp_err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 16'hA5A5, 16'hA5A5, 16'h0000},  // R2 whole request word
    '{3'd1, 16'h00F0, 16'hA5A5, 16'h00F0},  // R2 whole error word
    '{3'd2, 16'h0003, 16'hA5AD, 16'h00F0},  // R4 set request ch3
    '{3'd3, 16'h0000, 16'hA5AC, 16'h00F0},  // R5 clear request ch0
    '{3'd2, 16'h0030, 16'hA5AD, 16'h00F0},  // R7 bits 5:4 ignored, ch0
    '{3'd4, 16'hFF8F, 16'hA5AD, 16'h80F0},  // R7 high bits ignored, set err ch15
    '{3'd5, 16'h0004, 16'hA5AD, 16'h80E0},  // R5 clear err ch4
    '{3'd3, 16'h0040, 16'h0000, 16'h80E0},  // R6 clear all requests
    '{3'd4, 16'h0040, 16'h0000, 16'hFFFF},  // R6 set all error enables
    '{3'd6, 16'h1234, 16'h0000, 16'hFFFF},  // R8 unmapped write ignored
    '{3'd2, 16'h004A, 16'hFFFF, 16'hFFFF},  // R6 select-all beats ch field
    '{3'd5, 16'h0049, 16'hFFFF, 16'h0000}   // R6 clear all error enables
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    d = reg_rdata;
    reg_rd = 1'b0;
    #1;
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] v2;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 req_en in reset", req_en, 16'h0000);
    chk("R1 err_irq in reset", err_irq, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 request bitmap after reset", v, 16'h0000);
    rd(3'd1, v); chk("R1 error bitmap after reset", v, 16'h0000);

    // Table of register operations (R2 R4 R5 R6 R7 R8)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d);
      rd(3'd0, v);  chk($sformatf("R2 table %0d request readback", i), v, VEC[i].exp_req);
      rd(3'd1, v);  chk($sformatf("R2 table %0d error readback", i), v, VEC[i].exp_err);
      chk($sformatf("R2 table %0d req_en port", i), req_en, VEC[i].exp_req);
      rd(VEC[i].a, v);
      if (VEC[i].a >= 3'd2) chk($sformatf("R8 table %0d port reads zero", i), v, 16'h0000);
    end
    rd(3'd7, v); chk("R8 address 7 reads zero", v, 16'h0000);

    // R2 reads have no side effects
    rd(3'd0, v); rd(3'd0, v2);
    chk("R2 repeated read stable", v2, v);
    chk("R2 read leaves req_en", req_en, 16'hFFFF);

    // R3 registered AND of errors and enables
    wr(3'd1, 16'h00FF);
    @(negedge clk);
    chan_err = 16'h0F0F;
    #1;
    chk("R3 no request before edge", err_irq, 16'h0000);
    @(negedge clk);
    chk("R3 request one clock later", err_irq, 16'h000F);
    chan_err = 16'hF000;
    @(negedge clk);
    chk("R3 disabled channels silent", err_irq, 16'h0000);
    chan_err = 16'h0000;

    // R9 completion with and without the disable flag
    wr(3'd0, 16'hFFFF);
    @(negedge clk);
    major_done = 16'h0003; done_dis_req = 16'h0001;
    @(negedge clk);
    major_done = '0; done_dis_req = '0;
    chk("R9 flagged channel cleared, unflagged kept", req_en, 16'hFFFE);

    // R10 collision with single-channel set
    wr(3'd3, 16'h0040);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0005;
    major_done = 16'h0020; done_dis_req = 16'h0020;
    @(negedge clk);
    reg_wr = 1'b0; major_done = '0; done_dis_req = '0;
    chk("R10 hardware clear beats set", req_en, 16'h0000);

    // R10 collision with whole-word write
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'hFFFF;
    major_done = 16'h0004; done_dis_req = 16'h0004;
    @(negedge clk);
    reg_wr = 1'b0; major_done = '0; done_dis_req = '0;
    chk("R10 hardware clear beats word write", req_en, 16'hFFFB);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule